// File: doc/BRIEF.md
# Multi-Cycle Multiply/Divide Unit

This unit performs integer multiply and divide on an accumulator pair. It handles unsigned and signed operands at byte or word size. It also sign-extends a byte into a word and a word into a doubleword. A byte operation reads the full `W`-bit accumulator and an `H`-bit source, where `H = W/2`. A word operation reads a `2W`-bit value made of the high register above the accumulator, and a `W`-bit source. The results are new accumulator and high-register values plus carry and overflow flags. The unit latches its operands when `start_i` is seen while it is idle. It holds `busy_o` high while it works, then pulses `done_o` for one cycle.

Multiplication and sign extension finish one cycle after the start edge. Division runs a restoring shift-subtract loop that produces one quotient bit per cycle on magnitudes, then fixes the signs. A zero divisor, or a quotient that does not fit its destination, raises `div_err_o` together with `done_o` instead of producing a result. The unit only flags the error; any trap handling belongs to the surrounding logic.

Top module: `muldiv_unit`

## Requirements
- R1: After reset `busy_o`, `done_o`, `div_err_o`, `cf_o` and `of_o` are 0, and `acc_o` and `hi_o` are 0.
- R2: A `start_i` sampled while idle is accepted, and `busy_o` is high from the next cycle. `done_o` is a one-cycle pulse, with `busy_o` low in that cycle. A `start_i` that arrives while `busy_o` is high has no effect on the running operation or its results.
- R3: Counting clock edges after the accepting edge, `done_o` rises after 1 edge for multiply, sign extension, a reserved code or a zero divisor. A division with a nonzero divisor takes 2W+1 edges (33 at W=16).
- R4: The `op_i` codes are 0 unsigned multiply, 1 signed multiply, 2 unsigned divide, 3 signed divide and 4 sign extend. `word_i`=0 selects byte size and 1 selects word size. Unsigned byte multiply gives `acc_o` = acc[H-1:0] × src[H-1:0] with `hi_o` unchanged. Unsigned word multiply gives {`hi_o`,`acc_o`} = acc × src. In both cases `cf_o` = `of_o` = 1 exactly when the upper half of the product is nonzero.
- R5: Signed multiply forms the two's-complement product, placed as in R4. `cf_o` = `of_o` = 0 when the upper half only repeats the sign bit of the lower half, and 1 otherwise.
- R6: Unsigned byte divide places acc / src[H-1:0] in `acc_o`[H-1:0] and the remainder in `acc_o`[W-1:H], with `hi_o` unchanged. Unsigned word divide places {hi,acc} / src in `acc_o` and the remainder in `hi_o`.
- R7: Signed divide truncates the quotient toward zero, and the remainder takes the sign of the dividend. Results are placed as in R6.
- R8: Unsigned divide raises `div_err_o` when the divisor is zero, or when the quotient exceeds 2^H−1 at byte size or 2^W−1 at word size.
- R9: Signed divide raises `div_err_o` when the divisor is zero, or when the quotient lies outside −127..127 at byte size or −(2^(W−1)−1)..2^(W−1)−1 at word size. The most negative value is therefore an error.
- R10: With `div_err_o` high, `acc_o`, `hi_o`, `cf_o` and `of_o` equal the latched `acc_i`, `hi_i`, `cf_i` and `of_i`, and `div_err_o` is high only in the `done_o` cycle.
- R11: Sign extension at byte size sets `acc_o`[W-1:H] to copies of acc[H-1] and keeps `hi_o`. At word size it sets `hi_o` to copies of acc[W-1] and keeps `acc_o`. Sign extension and any division that completes without error copy `cf_i` and `of_i` to the flag outputs.
- R12: For op codes 5 to 7, all four results equal the latched inputs and `div_err_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| op_i | input | 3 | Operation code (R4) |
| word_i | input | 1 | 0 byte size, 1 word size |
| acc_i | input | W | Accumulator input |
| hi_i | input | W | High register input |
| src_i | input | W | Source operand |
| cf_i | input | 1 | Incoming carry flag |
| of_i | input | 1 | Incoming overflow flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_err_o | output | 1 | Divide error, valid with done_o |
| acc_o | output | W | New accumulator value |
| hi_o | output | W | New high register value |
| cf_o | output | 1 | Carry flag result |
| of_o | output | 1 | Overflow flag result |

## Verification
Each operation is launched at a falling edge and accepted at the following rising edge. From there the bench counts rising edges until `done_o` is seen at a falling edge. It compares that count with the expected value: 1 edge for multiply, extension, reserved codes and zero divisors, and 33 for a real division. All results are sampled in that same falling-edge window, when the registered outputs are stable. One cycle later the bench confirms that `done_o` has dropped. It also confirms that a second start issued in the middle of a division leaves both the latency and the results of the first operation intact.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    OP_MULU = 3'd0,
    OP_MULS = 3'd1,
    OP_DIVU = 3'd2,
    OP_DIVS = 3'd3,
    OP_SEXT = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_FIN  = 2'd2
  } st_e;
endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           sgn_i,
  input  logic           word_i,
  output logic [2*W-1:0] prod_o,
  output logic           ovf_o
);
  localparam int H = W / 2;
  localparam int D = 2 * W;

  logic [D-1:0] a_ext, b_ext;
  logic         ovf_byte, ovf_word;

  always_comb begin
    if (word_i) begin
      a_ext = {{W{sgn_i & a_i[W-1]}}, a_i};
      b_ext = {{W{sgn_i & b_i[W-1]}}, b_i};
    end else begin
      a_ext = {{(D-H){sgn_i & a_i[H-1]}}, a_i[H-1:0]};
      b_ext = {{(D-H){sgn_i & b_i[H-1]}}, b_i[H-1:0]};
    end
  end

  // low 2W bits are exact for both signed and unsigned operands
  assign prod_o = a_ext * b_ext;

  assign ovf_byte = sgn_i ? (prod_o[W-1:H] != {H{prod_o[H-1]}}) : (|prod_o[W-1:H]);
  assign ovf_word = sgn_i ? (prod_o[D-1:W] != {W{prod_o[W-1]}}) : (|prod_o[D-1:W]);
  assign ovf_o    = word_i ? ovf_word : ovf_byte;
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [2*W-1:0] dvd_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] quo_o,
  output logic [W-1:0]   rem_o,
  output logic           last_o
);
  localparam int D  = 2 * W;
  localparam int CW = $clog2(D);
  localparam logic [CW-1:0] LAST = CW'(D - 1);

  logic [D-1:0]  q_q;
  logic [W-1:0]  r_q, d_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic [W:0]    r_sh, diff;
  logic          ge;

  assign r_sh = {r_q, q_q[D-1]};
  assign diff = r_sh - {1'b0, d_q};
  assign ge   = ~diff[W];   // r_q < d_q keeps the difference below 2^W

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      r_q   <= '0;
      d_q   <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      q_q   <= dvd_i;
      r_q   <= '0;
      d_q   <= dvs_i;
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      q_q   <= {q_q[D-2:0], ge};
      r_q   <= ge ? diff[W-1:0] : r_sh[W-1:0];
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) act_q <= 1'b0;
    end
  end

  assign quo_o  = q_q;
  assign rem_o  = r_q;
  assign last_o = act_q && (cnt_q == LAST);

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (r_q < d_q)); // R6
  AST_NO_ZERO_DIVISOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (dvs_i != '0)); // R8
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic         word_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] src_i,
  input  logic         cf_i,
  input  logic         of_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         div_err_o,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] hi_o,
  output logic         cf_o,
  output logic         of_o
);
  localparam int H = W / 2;
  localparam int D = 2 * W;
  localparam logic [D-1:0] LIM_BU = {{(D-H){1'b0}}, {H{1'b1}}};
  localparam logic [D-1:0] LIM_BS = {{(D-H+1){1'b0}}, {(H-1){1'b1}}};
  localparam logic [D-1:0] LIM_WU = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [D-1:0] LIM_WS = {{(W+1){1'b0}}, {(W-1){1'b1}}};

  st_e          state_q;
  op_e          op_q;
  logic         word_q, cf_q, of_q, zdiv_q, qneg_q, rneg_q;
  logic [W-1:0] acc_q, hi_q, src_q;

  // operand preparation at the start edge
  op_e          op_in;
  logic         is_div, sgn_in, dvd_neg, dvs_neg, dvs_zero, accept, div_load;
  logic [D-1:0] dvd_raw, dvd_mag;
  logic [W-1:0] dvs_raw, dvs_mag;

  assign op_in  = op_e'(op_i);
  assign is_div = (op_in == OP_DIVU) || (op_in == OP_DIVS);
  assign sgn_in = (op_in == OP_DIVS);

  always_comb begin
    if (word_i) begin
      dvd_raw = {hi_i, acc_i};
      dvs_raw = src_i;
    end else begin
      dvd_raw = {{W{sgn_in & acc_i[W-1]}}, acc_i};
      dvs_raw = {{H{sgn_in & src_i[H-1]}}, src_i[H-1:0]};
    end
  end

  assign dvd_neg  = sgn_in & dvd_raw[D-1];
  assign dvs_neg  = sgn_in & dvs_raw[W-1];
  assign dvd_mag  = dvd_neg ? (~dvd_raw + 1'b1) : dvd_raw;
  assign dvs_mag  = dvs_neg ? (~dvs_raw + 1'b1) : dvs_raw;
  assign dvs_zero = (dvs_raw == '0);
  assign accept   = start_i && (state_q == ST_IDLE);
  assign div_load = accept && is_div && !dvs_zero;

  logic [D-1:0] prod, quo;
  logic [W-1:0] rem;
  logic         ovf, div_last;

  muldiv_mul #(.W(W)) u_mul (
    .a_i    (acc_q),
    .b_i    (src_q),
    .sgn_i  (op_q == OP_MULS),
    .word_i (word_q),
    .prod_o (prod),
    .ovf_o  (ovf)
  );

  muldiv_div #(.W(W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (div_load),
    .dvd_i  (dvd_mag),
    .dvs_i  (dvs_mag),
    .quo_o  (quo),
    .rem_o  (rem),
    .last_o (div_last)
  );

  // result selection in the finish cycle
  logic [D-1:0] q_lim, q_fix;
  logic [W-1:0] r_fix, acc_n, hi_n;
  logic         range_err, err_n, cf_n, of_n;

  always_comb begin
    if (word_q) q_lim = (op_q == OP_DIVS) ? LIM_WS : LIM_WU;
    else        q_lim = (op_q == OP_DIVS) ? LIM_BS : LIM_BU;
  end

  assign range_err = (quo > q_lim);
  assign q_fix     = qneg_q ? (~quo + 1'b1) : quo;
  assign r_fix     = rneg_q ? (~rem + 1'b1) : rem;

  always_comb begin
    acc_n = acc_q;
    hi_n  = hi_q;
    cf_n  = cf_q;
    of_n  = of_q;
    err_n = 1'b0;
    case (op_q)
      OP_MULU, OP_MULS: begin
        acc_n = prod[W-1:0];
        if (word_q) hi_n = prod[D-1:W];
        cf_n = ovf;
        of_n = ovf;
      end
      OP_DIVU, OP_DIVS: begin
        if (zdiv_q || range_err) begin
          err_n = 1'b1;
        end else if (word_q) begin
          acc_n = q_fix[W-1:0];
          hi_n  = r_fix;
        end else begin
          acc_n = {r_fix[H-1:0], q_fix[H-1:0]};
        end
      end
      OP_SEXT: begin
        if (word_q) hi_n = {W{acc_q[W-1]}};
        else        acc_n = {{H{acc_q[H-1]}}, acc_q[H-1:0]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_MULU;
      word_q    <= 1'b0;
      acc_q     <= '0;
      hi_q      <= '0;
      src_q     <= '0;
      cf_q      <= 1'b0;
      of_q      <= 1'b0;
      zdiv_q    <= 1'b0;
      qneg_q    <= 1'b0;
      rneg_q    <= 1'b0;
      done_o    <= 1'b0;
      div_err_o <= 1'b0;
      acc_o     <= '0;
      hi_o      <= '0;
      cf_o      <= 1'b0;
      of_o      <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      div_err_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= op_in;
          word_q  <= word_i;
          acc_q   <= acc_i;
          hi_q    <= hi_i;
          src_q   <= src_i;
          cf_q    <= cf_i;
          of_q    <= of_i;
          zdiv_q  <= is_div && dvs_zero;
          qneg_q  <= dvd_neg ^ dvs_neg;
          rneg_q  <= dvd_neg;
          state_q <= div_load ? ST_DIV : ST_FIN;
        end
        ST_DIV: if (div_last) state_q <= ST_FIN;
        ST_FIN: begin
          acc_o     <= acc_n;
          hi_o      <= hi_n;
          cf_o      <= cf_n;
          of_o      <= of_n;
          div_err_o <= err_n;
          done_o    <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R2
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o); // R2
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |-> done_o); // R10
  AST_ERR_HOLDS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |-> (acc_o == acc_q && hi_o == hi_q && cf_o == cf_q && of_o == of_q)); // R10
  AST_ERR_ONLY_DIVIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |-> (op_q == OP_DIVU || op_q == OP_DIVS)); // R12
endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
  localparam int W = 16;
  localparam int CLK_P = 10;
  localparam int DIV_LAT = 2 * W + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   op = '0;
  logic         word = 1'b0;
  logic [W-1:0] acc = '0, hi = '0, src = '0;
  logic         cf = 1'b0, of = 1'b0;
  logic         busy, done, derr, cf_o, of_o;
  logic [W-1:0] acc_o, hi_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] seed = 32'h1234_5679;

  muldiv_unit #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .word_i(word),
    .acc_i(acc), .hi_i(hi), .src_i(src), .cf_i(cf), .of_i(of),
    .busy_o(busy), .done_o(done), .div_err_o(derr),
    .acc_o(acc_o), .hi_o(hi_o), .cf_o(cf_o), .of_o(of_o)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 190000)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
  endtask

  function automatic logic [7:0] pick8(input int k);
    case (k % 16)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h07;
      4: return 8'h7F;  5: return 8'h80;  6: return 8'h81;  7: return 8'hFE;
      8: return 8'hFF;  9: return 8'h10;  10: return 8'h55; 11: return 8'hAA;
      12: return 8'h33; 13: return 8'hC8; 14: return 8'h09; default: return 8'h40;
    endcase
  endfunction

  // independent arithmetic model of the requirements
  task automatic model(input logic [2:0] o, input logic w, input logic [W-1:0] a,
                       input logic [W-1:0] h, input logic [W-1:0] s, input logic c, input logic f,
                       output logic [W-1:0] ea, output logic [W-1:0] eh, output logic ec,
                       output logic ef, output logic ee, output int lat, output string tag);
    longint x, y, p, q, r;
    ea = a; eh = h; ec = c; ef = f; ee = 1'b0; lat = 1; tag = "R12";
    case (o)
      3'd0, 3'd1: begin
        tag = (o == 3'd0) ? "R4" : "R5";
        if (o == 3'd0) begin
          x = w ? longint'(a) : longint'(a[7:0]);
          y = w ? longint'(s) : longint'(s[7:0]);
        end else begin
          x = w ? longint'($signed(a)) : longint'($signed(a[7:0]));
          y = w ? longint'($signed(s)) : longint'($signed(s[7:0]));
        end
        p = x * y;
        ea = p[15:0];
        if (w) eh = p[31:16];
        if (o == 3'd0) ec = w ? (p > 65535) : (p > 255);
        else           ec = w ? (p > 32767 || p < -32768) : (p > 127 || p < -128);
        ef = ec;
      end
      3'd2, 3'd3: begin
        tag = (o == 3'd2) ? "R6" : "R7";
        if (o == 3'd2) begin
          x = w ? longint'({h, a}) : longint'(a);
          y = w ? longint'(s) : longint'(s[7:0]);
        end else begin
          x = w ? longint'($signed({h, a})) : longint'($signed(a));
          y = w ? longint'($signed(s)) : longint'($signed(s[7:0]));
        end
        if (y == 0) begin
          ee = 1'b1;
        end else begin
          lat = DIV_LAT;
          q = x / y;
          r = x % y;
          if (o == 3'd2) ee = w ? (q > 65535) : (q > 255);
          else           ee = w ? (q > 32767 || q < -32767) : (q > 127 || q < -127);
          if (!ee) begin
            if (w) begin ea = q[15:0]; eh = r[15:0]; end
            else ea = {r[7:0], q[7:0]};
          end
        end
        if (ee) tag = (o == 3'd2) ? "R8,R10" : "R9,R10";
      end
      3'd4: begin
        tag = "R11";
        if (w) eh = {W{a[15]}};
        else   ea = {{8{a[7]}}, a[7:0]};
      end
      default: ;
    endcase
  endtask

  task automatic run_op(input logic [2:0] o, input logic w, input logic [W-1:0] a,
                        input logic [W-1:0] h, input logic [W-1:0] s, input logic c,
                        input logic f, input bit poke);
    logic [W-1:0] ea, eh;
    logic ec, ef, ee;
    int lat, n;
    string tag;
    model(o, w, a, h, s, c, f, ea, eh, ec, ef, ee, lat, tag);
    op = o; word = w; acc = a; hi = h; src = s; cf = c; of = f; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2", "busy after accept", 64'(busy), 64'd1);
    n = 0;
    while (done !== 1'b1 && n < 100) begin
      if (poke && n == 4) begin
        // R2: second start mid-operation must be ignored
        op = 3'd0; word = 1'b1; acc = 16'h1111; hi = 16'h2222; src = 16'h0003; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(n == lat, "R3", "latency", 64'(n), 64'(lat));
    chk(busy === 1'b0, "R2", "busy low with done", 64'(busy), 64'd0);
    chk({acc_o, hi_o, cf_o, of_o, derr} === {ea, eh, ec, ef, ee}, tag,
        $sformatf("op%0d w%0d a=%h h=%h s=%h {acc,hi,cf,of,err}", o, w, a, h, s),
        64'({acc_o, hi_o, cf_o, of_o, derr}), 64'({ea, eh, ec, ef, ee}));
    @(negedge clk);
    chk(done === 1'b0 && derr === 1'b0, "R2", "done single pulse", 64'({done, derr}), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, derr, cf_o, of_o} === 5'b0 && acc_o === '0 && hi_o === '0, "R1",
        "outputs in reset", 64'({busy, done, derr, cf_o, of_o, acc_o, hi_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, derr, cf_o, of_o} === 5'b0 && acc_o === '0 && hi_o === '0, "R1",
        "outputs after reset", 64'({busy, done, derr, cf_o, of_o, acc_o, hi_o}), 64'd0);

    // byte multiply sweep (R4, R5)
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        run_op(3'd0, 1'b0, {pick8(j + 3), pick8(i)}, 16'hBEEF, {pick8(i + 5), pick8(j)}, 1'b0, 1'b1, 1'b0);
        run_op(3'd1, 1'b0, {pick8(j + 7), pick8(i)}, 16'h1234, {pick8(i + 2), pick8(j)}, 1'b1, 1'b0, 1'b0);
      end

    // word multiply edges and random (R4, R5)
    run_op(3'd0, 1'b1, 16'hFFFF, 16'h0, 16'hFFFF, 1'b0, 1'b0, 1'b0);
    run_op(3'd1, 1'b1, 16'h8000, 16'h0, 16'h8000, 1'b0, 1'b0, 1'b0);
    run_op(3'd1, 1'b1, 16'hFFFF, 16'h0, 16'h7FFF, 1'b0, 1'b0, 1'b0);
    run_op(3'd0, 1'b1, 16'h0100, 16'h5A5A, 16'h00FF, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 150; k++) begin
      rnd();
      run_op(3'(k & 1), 1'b1, seed[15:0], seed[31:16], seed[31:16] >> (k % 16), 1'b0, 1'b0, 1'b0);
    end

    // byte divide sweep (R6..R10)
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 16; j++) begin
        rnd();
        run_op(3'd2, 1'b0, seed[15:0] >> (i % 12), 16'hC0DE, {8'hA5, pick8(j)}, 1'(i), 1'(j), 1'b0);
        run_op(3'd3, 1'b0, seed[31:16] >> (i % 12) | ((i % 3 == 0) ? 16'hF000 : 16'h0),
               16'h7777, {8'h3C, pick8(j)}, 1'(j), 1'(i), 1'b0);
      end
    run_op(3'd2, 1'b0, 16'h00FF, 16'h0, 16'h0001, 1'b0, 1'b0, 1'b0); // R6 max quotient
    run_op(3'd2, 1'b0, 16'h0100, 16'h0, 16'h0001, 1'b1, 1'b0, 1'b0); // R8 overflow
    run_op(3'd3, 1'b0, 16'hFF81, 16'h0, 16'h0001, 1'b0, 1'b0, 1'b0); // R7 -127 ok
    run_op(3'd3, 1'b0, 16'hFF80, 16'h0, 16'h0001, 1'b0, 1'b1, 1'b0); // R9 -128 err
    run_op(3'd3, 1'b0, 16'h0080, 16'h0, 16'h00FF, 1'b1, 1'b1, 1'b0); // R9 128/-1
    run_op(3'd3, 1'b0, 16'hFFF9, 16'h0, 16'h0002, 1'b0, 1'b0, 1'b0); // R7 -7/2

    // word divide (R6..R10)
    run_op(3'd2, 1'b1, 16'hFFFF, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b0);
    run_op(3'd2, 1'b1, 16'h0000, 16'h0001, 16'h0001, 1'b0, 1'b1, 1'b0);
    run_op(3'd2, 1'b1, 16'h1234, 16'h0012, 16'h0000, 1'b1, 1'b0, 1'b0);
    run_op(3'd3, 1'b1, 16'h8000, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b0);
    run_op(3'd3, 1'b1, 16'h8001, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b0);
    run_op(3'd3, 1'b1, 16'h0000, 16'h8000, 16'hFFFF, 1'b1, 1'b1, 1'b0);
    run_op(3'd3, 1'b1, 16'hFFF9, 16'hFFFF, 16'hFFFE, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 200; k++) begin
      logic [W-1:0] a, h, s;
      rnd(); a = seed[15:0]; h = seed[31:16] >> (k % 17);
      rnd(); s = (k % 23 == 0) ? 16'h0 : seed[15:0] >> (k % 13);
      run_op(3'd2 + 3'(k & 1), 1'b1, a, h, s, 1'(k >> 1), 1'(k >> 2), 1'b0);
    end

    // sign extension and reserved codes (R11, R12)
    for (int k = 0; k < 64; k++) begin
      rnd();
      run_op(3'd4, 1'(k & 1), seed[15:0], seed[31:16], 16'h0, 1'(k >> 1), 1'(k >> 2), 1'b0);
    end
    for (int k = 5; k < 8; k++)
      run_op(3'(k), 1'(k & 1), 16'h8765, 16'h4321, 16'h0, 1'b1, 1'(k), 1'b0);

    // start while busy ignored (R2)
    run_op(3'd2, 1'b1, 16'h5678, 16'h0012, 16'h0345, 1'b1, 1'b0, 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R2", "no second operation after ignored start",
          64'({busy, done}), 64'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule